// File: doc/BRIEF.md
# I2C Byte Shift Engine

This block moves one byte at a time across a two-wire bus in I2C fashion. It watches synchronised copies of the clock and data lines and counts clock pulses within a byte: eight data bits, most significant first, then a ninth acknowledge bit. It shifts received bits into a byte register and drives the data line open-drain from a byte-wide transmit register. It also reports start and stop conditions, the end of transmission and reception, and acknowledge outcomes as single-cycle event pulses. Clock generation, arbitration and glitch filtering belong to neighbouring logic.

Two configuration inputs change how events are reported and when the 9-bit receive buffer is written. The event-style bit picks between acknowledge reporting (transmit event on a not-acknowledge, receive event on an acknowledge) and plain transmit/receive reporting. The output-delay bit holds each new data-line level back by a fixed number of system clocks after the clock line falls. With event style 1 and delay on, the receive buffer is written twice around the ninth bit, first with a split layout and then with the plain byte. Both bits are captured only while the unit is disabled. While disabled, the data-line output follows a preset level.

Top module: `i2c_shift_unit`

## Requirements
- R1: While `enable` is low, `sda_oe` equals the inverse of `sda_preset` (1 means pull the line low), no event pulses are produced, and `rx_buf` keeps its value; after reset `rx_buf` is 0.
- R2: `cfg_irq_style` and `cfg_clk_delay` are captured only while `enable` is low; changes while enabled have no effect until the next disabled period.
- R3: SDA falling while SCL is high (start), or SDA rising while SCL is high (stop), produces one `evt_cond` pulse. Both reset the bit count to zero.
- R4: Transmit: on the SCL fall that follows a start or a ninth bit, `tx_data` and `tx_ninth` are captured and bit 7 is presented. Each later fall presents the next lower bit. After the eighth fall `tx_ninth` is presented. The line level is the inverse of `sda_oe`.
- R5: Event style 0: at the SCL rise of the ninth bit, `rx_buf` becomes {ninth bit, received byte}, first received bit in bit 7. The ninth bit sampled high gives one `evt_tx` pulse, and sampled low gives one `evt_rx` pulse.
- R6: Event style 1, delay off: `evt_tx` pulses at the SCL rise of the ninth bit. At the SCL fall ending the ninth bit, `rx_buf` becomes {ninth bit, received byte} and `evt_rx` pulses.
- R7: Event style 1, delay on: at the SCL fall ending the eighth bit, `rx_buf` becomes {eighth bit, 0, bits 1..7 in bits 6..0}. At the SCL rise of the ninth bit, bits 7..0 become the full byte and bit 8 is kept. `evt_tx` and `evt_rx` both pulse at the SCL fall ending the ninth bit.
- R8: With delay off, a new data-line level appears in the cycle after the SCL fall is detected. With delay on, it appears `OUT_DLY` cycles later than that.
- R9: Every event output is high for exactly one system clock per occurrence, and no event occurs apart from those above.
- R10: The bit count runs 0 to 9, rising on each SCL rise and wrapping to 0 on the SCL fall ending the ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Unit active; low holds it idle and opens configuration capture |
| cfg_irq_style | input | 1 | 0: acknowledge-style events, 1: transmit/receive-style events |
| cfg_clk_delay | input | 1 | 1: delay data-line output updates |
| sda_preset | input | 1 | Data-line level while disabled |
| scl_in | input | 1 | Clock line sample (asynchronous) |
| sda_in | input | 1 | Data line sample (asynchronous) |
| tx_data | input | 8 | Transmit byte |
| tx_ninth | input | 1 | Level sent in the ninth bit (1 releases the line) |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_buf | output | 9 | Receive buffer |
| evt_tx | output | 1 | Transmit / not-acknowledge event pulse |
| evt_rx | output | 1 | Receive / acknowledge event pulse |
| evt_cond | output | 1 | Start or stop condition pulse |

## Verification
The embedded properties watch, on every cycle, that event pulses never stretch, that a start clears the bit count, that the configuration stays frozen while enabled, and that the disabled state holds the preset level and the buffer. They also check that undelayed output changes follow a clock fall and that delayed ones never appear the next cycle. Only the bench's bus scenarios can show the values and order of buffer writes and events in each of the three modes: the double write with its split layout, the acknowledge-driven choice of event, the bit-by-bit transmit sequence across repeated starts, and the fact that configuration pins toggled mid-frame change nothing.

// File: rtl/i2c_su_pkg.sv
package i2c_su_pkg;
  localparam int unsigned DATA_BITS = 8;
  localparam int unsigned CNT_W     = 4;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/i2c_su_sync.sv
module i2c_su_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/i2c_su_busmon.sv
module i2c_su_busmon
  import i2c_su_pkg::*;
#(
  parameter int unsigned LAST = 9,
  parameter int unsigned CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          scl_s,
  input  logic          sda_s,
  output bus_ev_t       ev,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST_C = CW'(LAST);

  logic          scl_q, sda_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    ev.rise  = en & scl_s & ~scl_q;
    ev.fall  = en & ~scl_s & scl_q;
    ev.start = en & scl_s & scl_q & sda_q & ~sda_s;
    ev.stop  = en & scl_s & scl_q & ~sda_q & sda_s;
  end

  always_comb begin
    cnt_nxt = cnt;
    if (!en)                          cnt_nxt = '0;
    else if (ev.start || ev.stop)     cnt_nxt = '0;
    else if (ev.rise && cnt != LAST_C) cnt_nxt = cnt + 1'b1;
    else if (ev.fall && cnt == LAST_C) cnt_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      cnt   <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      cnt   <= cnt_nxt;
    end
  end

  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ev.start |=> (cnt == '0)); // R3
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= LAST_C)); // R10
  AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.fall && cnt == LAST_C && !ev.start && !ev.stop) |=> (cnt == '0)); // R10
endmodule

// File: rtl/i2c_su_txpath.sv
module i2c_su_txpath #(
  parameter int unsigned DW      = 8,
  parameter int unsigned CW      = 4,
  parameter int unsigned OUT_DLY = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dly,
  input  logic          preset,
  input  logic          scl_fall,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_ninth,
  output logic          out_bit
);
  localparam logic [CW-1:0] LAST_DATA = CW'(DW);
  localparam logic [CW-1:0] NINTH     = CW'(DW + 1);
  localparam int unsigned   DLW       = $clog2(OUT_DLY) + 1;
  localparam logic [DLW-1:0] DLY_LOAD = DLW'(OUT_DLY - 1);

  logic [DW-1:0]  tsh, tsh_nxt;
  logic           tnin, tnin_nxt;
  logic           out_nxt;
  logic           pend_bit, pend_bit_nxt;
  logic           pend_act, pend_act_nxt;
  logic [DLW-1:0] dcnt, dcnt_nxt;
  logic           upd;
  logic           nb;

  // which bit goes out next
  always_comb begin
    upd      = 1'b0;
    nb       = out_bit;
    tsh_nxt  = tsh;
    tnin_nxt = tnin;
    if (en && scl_fall) begin
      if (cnt == '0 || cnt == NINTH) begin
        upd      = 1'b1;
        nb       = tx_data[DW-1];
        tsh_nxt  = {tx_data[DW-2:0], 1'b0};
        tnin_nxt = tx_ninth;
      end else if (cnt < LAST_DATA) begin
        upd     = 1'b1;
        nb      = tsh[DW-1];
        tsh_nxt = {tsh[DW-2:0], 1'b0};
      end else if (cnt == LAST_DATA) begin
        upd = 1'b1;
        nb  = tnin;
      end
    end
  end

  // when it goes out
  always_comb begin
    out_nxt      = out_bit;
    pend_bit_nxt = pend_bit;
    pend_act_nxt = pend_act;
    dcnt_nxt     = dcnt;
    if (!en) begin
      out_nxt      = preset;
      pend_act_nxt = 1'b0;
      dcnt_nxt     = '0;
    end else if (upd && !dly) begin
      out_nxt      = nb;
      pend_act_nxt = 1'b0;
    end else if (upd) begin
      pend_bit_nxt = nb;
      pend_act_nxt = 1'b1;
      dcnt_nxt     = DLY_LOAD;
    end else if (pend_act) begin
      if (dcnt == '0) begin
        out_nxt      = pend_bit;
        pend_act_nxt = 1'b0;
      end else begin
        dcnt_nxt = dcnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh      <= '0;
      tnin     <= 1'b1;
      out_bit  <= 1'b1;
      pend_bit <= 1'b1;
      pend_act <= 1'b0;
      dcnt     <= '0;
    end else begin
      tsh      <= tsh_nxt;
      tnin     <= tnin_nxt;
      out_bit  <= out_nxt;
      pend_bit <= pend_bit_nxt;
      pend_act <= pend_act_nxt;
      dcnt     <= dcnt_nxt;
    end
  end

  AST_PRESET_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!en)) |-> (out_bit == $past(preset))); // R1
  AST_NODELAY_FOLLOWS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(rst_n) && !dly && !$stable(out_bit)) |-> $past(scl_fall)); // R8
  AST_DELAY_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dly && scl_fall) |=> $stable(out_bit)); // R8
endmodule

// File: rtl/i2c_su_rxpath.sv
module i2c_su_rxpath
  import i2c_su_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          style,
  input  logic          dly,
  input  bus_ev_t       ev,
  input  logic [CW-1:0] cnt,
  input  logic          sda_s,
  output logic [DW:0]   rbuf,
  output logic          evt_tx,
  output logic          evt_rx,
  output logic          evt_cond
);
  localparam logic [CW-1:0] LAST_DATA = CW'(DW);
  localparam logic [CW-1:0] NINTH     = CW'(DW + 1);

  logic [DW-1:0] sh, sh_nxt;
  logic          ack_q, ack_nxt;
  logic [DW:0]   rbuf_nxt;
  logic          tx_nxt, rx_nxt, cond_nxt;
  logic          ninth_rise, eighth_fall, ninth_fall;

  always_comb begin
    ninth_rise  = ev.rise && (cnt == LAST_DATA);
    eighth_fall = ev.fall && (cnt == LAST_DATA);
    ninth_fall  = ev.fall && (cnt == NINTH);
  end

  always_comb begin
    sh_nxt   = sh;
    ack_nxt  = ack_q;
    rbuf_nxt = rbuf;
    tx_nxt   = 1'b0;
    rx_nxt   = 1'b0;
    cond_nxt = 1'b0;
    if (!en) begin
      sh_nxt = '0;
    end else begin
      cond_nxt = ev.start | ev.stop;
      if (ev.rise && cnt < LAST_DATA) sh_nxt = {sh[DW-2:0], sda_s};
      if (ninth_rise) ack_nxt = sda_s;
      if (!style) begin
        if (ninth_rise) begin
          rbuf_nxt = {sda_s, sh};
          tx_nxt   = sda_s;
          rx_nxt   = ~sda_s;
        end
      end else if (!dly) begin
        tx_nxt = ninth_rise;
        rx_nxt = ninth_fall;
        if (ninth_fall) rbuf_nxt = {ack_q, sh};
      end else begin
        tx_nxt = ninth_fall;
        rx_nxt = ninth_fall;
        if (eighth_fall)     rbuf_nxt = {sh[0], 1'b0, sh[DW-1:1]};
        else if (ninth_rise) rbuf_nxt = {rbuf[DW], sh};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      ack_q    <= 1'b1;
      rbuf     <= '0;
      evt_tx   <= 1'b0;
      evt_rx   <= 1'b0;
      evt_cond <= 1'b0;
    end else begin
      sh       <= sh_nxt;
      ack_q    <= ack_nxt;
      rbuf     <= rbuf_nxt;
      evt_tx   <= tx_nxt;
      evt_rx   <= rx_nxt;
      evt_cond <= cond_nxt;
    end
  end

  AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx |=> !evt_tx); // R9
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx |=> !evt_rx); // R9
  AST_COND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cond |=> !evt_cond); // R3
  AST_ACK_STYLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !style |-> !(evt_tx && evt_rx)); // R5
  AST_BUF_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!en)) |-> $stable(rbuf)); // R1
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(evt_tx || evt_rx || evt_cond)); // R1
endmodule

// File: rtl/i2c_shift_unit.sv
module i2c_shift_unit
  import i2c_su_pkg::*;
#(
  parameter int unsigned DW       = DATA_BITS,
  parameter int unsigned OUT_DLY  = 8,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_irq_style,
  input  logic          cfg_clk_delay,
  input  logic          sda_preset,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_ninth,
  output logic          sda_oe,
  output logic [DW:0]   rx_buf,
  output logic          evt_tx,
  output logic          evt_rx,
  output logic          evt_cond
);
  localparam int unsigned LAST = DW + 1;
  localparam int unsigned CW   = $clog2(LAST + 1);

  logic [1:0]    rst_pipe;
  logic          rst_n_i;
  logic          style_q, dly_q, style_nxt, dly_nxt;
  logic [1:0]    lines_s;
  bus_ev_t       ev;
  logic [CW-1:0] cnt;
  logic          out_bit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  always_comb begin
    style_nxt = style_q;
    dly_nxt   = dly_q;
    if (!enable) begin
      style_nxt = cfg_irq_style;
      dly_nxt   = cfg_clk_delay;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      style_q <= 1'b0;
      dly_q   <= 1'b0;
    end else begin
      style_q <= style_nxt;
      dly_q   <= dly_nxt;
    end
  end

  i2c_su_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_i),
    .d_in ({scl_in, sda_in}),
    .d_out(lines_s)
  );

  i2c_su_busmon #(.LAST(LAST), .CW(CW)) u_busmon (
    .clk  (clk),
    .rst_n(rst_n_i),
    .en   (enable),
    .scl_s(lines_s[1]),
    .sda_s(lines_s[0]),
    .ev   (ev),
    .cnt  (cnt)
  );

  i2c_su_txpath #(.DW(DW), .CW(CW), .OUT_DLY(OUT_DLY)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .en      (enable),
    .dly     (dly_q),
    .preset  (sda_preset),
    .scl_fall(ev.fall),
    .cnt     (cnt),
    .tx_data (tx_data),
    .tx_ninth(tx_ninth),
    .out_bit (out_bit)
  );

  i2c_su_rxpath #(.DW(DW), .CW(CW)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .en      (enable),
    .style   (style_q),
    .dly     (dly_q),
    .ev      (ev),
    .cnt     (cnt),
    .sda_s   (lines_s[0]),
    .rbuf    (rx_buf),
    .evt_tx  (evt_tx),
    .evt_rx  (evt_rx),
    .evt_cond(evt_cond)
  );

  assign sda_oe = ~out_bit;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($past(rst_n_i) && $past(enable)) |-> $stable({style_q, dly_q})); // R2
endmodule

// File: tb/i2c_shift_unit_test.sv
module i2c_shift_unit_test;
  localparam int K_BUF = 0, K_COND = 1, K_TX = 2, K_RX = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       cfg_irq_style = 1'b0;
  logic       cfg_clk_delay = 1'b0;
  logic       sda_preset = 1'b0;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ninth = 1'b1;
  logic       sda_oe;
  logic [8:0] rx_buf;
  logic       evt_tx, evt_rx, evt_cond;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;
  bit  mon_on   = 0;
  bit  cur_style = 0, cur_dly = 0;
  logic [8:0] prev_buf = '0;

  int         q_kind[$];
  logic [8:0] q_val[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  i2c_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_irq_style(cfg_irq_style), .cfg_clk_delay(cfg_clk_delay),
    .sda_preset(sda_preset), .scl_in(scl_in), .sda_in(sda_in),
    .tx_data(tx_data), .tx_ninth(tx_ninth), .sda_oe(sda_oe),
    .rx_buf(rx_buf), .evt_tx(evt_tx), .evt_rx(evt_rx), .evt_cond(evt_cond)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int k, input logic [8:0] v, input string tag);
    q_kind.push_back(k);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic pop_cmp(input int k, input logic [8:0] v);
    int         ek;
    logic [8:0] ev;
    string      tg;
    if (q_kind.size() == 0) begin
      check(0, "R9", "unexpected item kind", k, -1);
      return;
    end
    ek = q_kind.pop_front();
    ev = q_val.pop_front();
    tg = q_tag.pop_front();
    check(ek == k, tg, "item kind", k, ek);
    if (ek == K_BUF && k == K_BUF) check(v == ev, tg, "rx_buf value", int'(v), int'(ev));
  endtask

  // monitor: pops the scoreboard in a fixed per-cycle order
  always @(negedge clk) begin
    if (mon_on) begin
      if (rx_buf !== prev_buf) begin
        pop_cmp(K_BUF, rx_buf);
        prev_buf = rx_buf;
      end
      if (evt_cond) pop_cmp(K_COND, '0);
      if (evt_tx)   pop_cmp(K_TX, '0);
      if (evt_rx)   pop_cmp(K_RX, '0);
    end
  end

  function automatic bit expb(input logic [7:0] tx, input bit tn, input int k);
    return (k <= 8) ? tx[8-k] : tn;
  endfunction

  task automatic drive_bit(input int k, input bit line, input logic [7:0] tx, input bit tn);
    wcyc(6);
    if (k >= 2 && expb(tx, tn, k) != expb(tx, tn, k-1))
      check(~sda_oe == (cur_dly ? expb(tx, tn, k-1) : expb(tx, tn, k)), "R8",
            $sformatf("line level shortly after fall, bit %0d", k),
            int'(~sda_oe), int'(cur_dly ? expb(tx, tn, k-1) : expb(tx, tn, k)));
    sda_in = line;
    wcyc(14);
    scl_in = 1'b1;
    wcyc(10);
    check(~sda_oe == expb(tx, tn, k), "R4", $sformatf("transmit bit %0d", k),
          int'(~sda_oe), int'(expb(tx, tn, k)));
    wcyc(10);
    scl_in = 1'b0;
  endtask

  task automatic do_start();
    if (scl_in == 1'b0) begin
      sda_in = 1'b1;
      wcyc(10);
      scl_in = 1'b1;
      wcyc(10);
    end
    push(K_COND, '0, "R3");
    sda_in = 1'b0;
    wcyc(20);
    scl_in = 1'b0;
  endtask

  task automatic do_stop();
    sda_in = 1'b0;
    wcyc(10);
    scl_in = 1'b1;
    wcyc(10);
    push(K_COND, '0, "R3");
    sda_in = 1'b1;
    wcyc(20);
  endtask

  task automatic do_byte(input logic [7:0] d, input bit n);
    if (!cur_style) begin
      push(K_BUF, {n, d}, "R5");
      push(n ? K_TX : K_RX, '0, "R5");
    end else if (!cur_dly) begin
      push(K_TX, '0, "R6");
      push(K_BUF, {n, d}, "R6");
      push(K_RX, '0, "R6");
    end else begin
      push(K_BUF, {d[0], 1'b0, d[7:1]}, "R7");
      push(K_BUF, {d[0], d}, "R7");
      push(K_TX, '0, "R7");
      push(K_RX, '0, "R7");
    end
    for (int k = 1; k <= 8; k++) drive_bit(k, d[8-k], tx_data, tx_ninth);
    drive_bit(9, n, tx_data, tx_ninth);
  endtask

  task automatic go_mode(input bit st, input bit dl, input logic [7:0] tx, input bit tn);
    enable = 1'b0;
    wcyc(2);
    sda_preset = 1'b1;
    wcyc(3);
    check(sda_oe == 1'b0, "R1", "released while disabled, preset 1", int'(sda_oe), 0);
    cfg_irq_style = st;
    cfg_clk_delay = dl;
    cur_style = st;
    cur_dly = dl;
    tx_data = tx;
    tx_ninth = tn;
    wcyc(2);
    enable = 1'b1;
    wcyc(5);
  endtask

  initial begin
    wcyc(4);
    rst_n = 1'b1;
    wcyc(5);
    // R1: reset and disabled state
    check(sda_oe == 1'b1, "R1", "pull low while disabled, preset 0", int'(sda_oe), 1);
    check(rx_buf == 9'h000, "R1", "rx_buf after reset", int'(rx_buf), 0);
    check(!(evt_tx || evt_rx || evt_cond), "R1", "events while disabled",
          int'({evt_tx, evt_rx, evt_cond}), 0);
    // bus activity while disabled must give nothing
    sda_in = 1'b0;
    wcyc(10);
    sda_in = 1'b1;
    wcyc(10);
    check(!(evt_tx || evt_rx || evt_cond), "R1", "events after disabled bus activity",
          int'({evt_tx, evt_rx, evt_cond}), 0);
    prev_buf = rx_buf;
    mon_on = 1'b1;

    // acknowledge-style events (R5)
    go_mode(1'b0, 1'b0, 8'hAA, 1'b1);
    do_start();
    do_byte(8'hA5, 1'b0);
    do_byte(8'h5A, 1'b1);
    do_stop();

    // transmit/receive style, no delay; pins toggled while enabled (R2, R6)
    go_mode(1'b1, 1'b0, 8'hAA, 1'b1);
    do_start();
    cfg_irq_style = 1'b0;
    cfg_clk_delay = 1'b1;
    do_byte(8'hC3, 1'b0);
    do_byte(8'h96, 1'b1);
    do_stop();

    // delayed output, double buffer load, repeated start (R7, R8, R10)
    go_mode(1'b1, 1'b1, 8'h55, 1'b0);
    do_start();
    do_byte(8'h69, 1'b1);
    do_start();
    do_byte(8'hF0, 1'b0);
    do_stop();

    // acknowledge style with delayed output
    go_mode(1'b0, 1'b1, 8'h55, 1'b0);
    do_start();
    do_byte(8'h3C, 1'b1);
    do_stop();

    wcyc(20);
    check(q_kind.size() == 0, "R9", "expected items left unseen", q_kind.size(), 0);
    enable = 1'b0;
    sda_preset = 1'b0;
    wcyc(4);
    check(sda_oe == 1'b1, "R1", "pull low after disable, preset 0", int'(sda_oe), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule